// File: doc/BRIEF.md
# Tracking Position Counter Interface

This block is the digital back end of a tracking angle converter. An upstream loop delivers one count strobe per step of shaft motion, together with a direction bit. The block keeps a position counter whose resolution is picked at run time (10, 12, 14 or 16 bits). It flags each change with a busy window and a wrap pulse, and it reports the last direction of travel.

A host reads the position through a 16-bit tri-state bus. Reads come from an output latch that takes a new value only when the busy window closes. An active-low hold input can freeze that latch. A byte-select input picks which byte appears on the upper eight lines, so an 8-bit host can read the value in two passes. While the load input is low, the same pins turn into inputs and preset the counter.

Top module: `trk_pos_ctr`

## Requirements
- R1: After reset the counter and output latch read zero, busy and wrap_pulse are low, and dir is high.
- R2: res_sel picks the resolution: 00 selects 10 bits, 01 selects 12, 10 selects 14 and 11 selects 16. The position is left-aligned in 16 bits with the unused low bits at zero, so one count changes the value by 2^(16-width).
- R3: A cnt_stb cycle with load_n high moves the counter by one count, up when cnt_up is 1 and down when it is 0. From the next cycle, dir equals that cnt_up.
- R4: wrap_pulse goes high for exactly one cycle, in the cycle after a count that goes from all ones to zero (up) or from zero to all ones (down), at the selected width. It is low at all other times.
- R5: busy rises in the cycle after a count strobe or a load cycle. It stays high for BUSY_CYC cycles after the last such cycle, then falls.
- R6: The output latch copies the counter in the cycle where busy falls, but only if hold_n is high. While hold_n is low it keeps its old value.
- R7: The block drives bus_io only when oe_n is low and load_n is high. Otherwise it leaves the bus in high impedance.
- R8: bus_io[7:0] always carries latch bits [7:0]. bus_io[15:8] carries latch bits [15:8] when hi_byte is 1, and latch bits [7:0] when it is 0.
- R9: A cycle with load_n low presets the counter from bus_io, with the low bits cleared by the resolution mask. The preset takes priority over a cnt_stb in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_stb | input | 1 | One-cycle count strobe |
| cnt_up | input | 1 | Direction of the count: 1 counts up |
| res_sel | input | 2 | Resolution select |
| hold_n | input | 1 | Low freezes the output latch |
| oe_n | input | 1 | Low enables the bus drivers |
| hi_byte | input | 1 | Byte select for bus_io[15:8] |
| load_n | input | 1 | Low presets the counter from the bus |
| bus_io | inout | 16 | Data bus |
| busy | output | 1 | Position is changing; latch not valid |
| dir | output | 1 | Last direction of travel |
| wrap_pulse | output | 1 | One-cycle pulse on a wrap |

## Verification
The bench aims at wraps in both directions at the 10-, 12-, 14- and 16-bit widths. A design that tests for wrap at a fixed width would miss the 10-bit rollover, and one that leaves the low bits unmasked would show the wrong step size after a preset. The bench also drives a preset together with a count strobe, where a design with the wrong priority would be one count off. It checks that a held latch stays at its old value through a whole busy window. Finally, the bench drives its own pattern onto the bus while the block should be silent, and a driver that ignores load_n or oe_n would corrupt that pattern.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {
    RES_10 = 2'b00,
    RES_12 = 2'b01,
    RES_14 = 2'b10,
    RES_16 = 2'b11
  } res_e;

  // number of unused low bits at a given resolution
  function automatic int unsigned res_drop(input res_e r);
    return 6 - 2 * int'(r);
  endfunction

  function automatic logic [DATA_W-1:0] res_step(input res_e r);
    return DATA_W'(1) << res_drop(r);
  endfunction

  function automatic logic [DATA_W-1:0] res_mask(input res_e r);
    return ~(res_step(r) - DATA_W'(1));
  endfunction
endpackage

// File: rtl/trk_counter.sv
module trk_counter
  import trk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              up,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic [1:0]        res_sel,
  output logic [DATA_W-1:0] pos,
  output logic              dir,
  output logic              wrap
);
  logic [DATA_W-1:0] mask_w, step_w, pos_m;
  logic [DATA_W-1:0] pos_q, pos_d;
  logic              dir_q, dir_d;
  logic              wrap_q, wrap_d;
  logic              upd_en;

  always_comb begin
    mask_w = res_mask(res_e'(res_sel));
    step_w = res_step(res_e'(res_sel));
    pos_m  = pos_q & mask_w;
    pos_d  = pos_q;
    dir_d  = dir_q;
    wrap_d = 1'b0;
    upd_en = load_en | step_en;
    if (load_en) begin
      pos_d = load_val & mask_w;
    end else if (step_en) begin
      dir_d = up;
      if (up) begin
        pos_d  = pos_m + step_w;
        wrap_d = (pos_m == mask_w);
      end else begin
        pos_d  = pos_m - step_w;
        wrap_d = (pos_m == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      dir_q <= 1'b1;
    end else if (upd_en) begin
      pos_q <= pos_d;
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrap_q <= 1'b0;
    else        wrap_q <= wrap_d;
  end

  assign pos  = pos_q;
  assign dir  = dir_q;
  assign wrap = wrap_q;

  assert_wrap_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> $past(step_en) && !$past(load_en));
  assert_wrap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |=> !wrap_q);
  assert_dir_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> dir_q == $past(up));
  assert_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (pos_q & ~$past(mask_w)) == '0);
endmodule

// File: rtl/trk_busy_timer.sv
module trk_busy_timer #(
  parameter int unsigned BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fall
);
  localparam int unsigned TW = $clog2(BUSY_CYC + 1);

  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    if (start)            tmr_d = TW'(BUSY_CYC);
    else if (tmr_q != '0) tmr_d = tmr_q - TW'(1);
    else                  tmr_d = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign busy = (tmr_q != '0);
  assign fall = (tmr_q == TW'(1)) && !start;

  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_busy_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !busy);
endmodule

// File: rtl/trk_out_latch.sv
module trk_out_latch
  import trk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              hold_n,
  input  logic [DATA_W-1:0] pos,
  input  logic              oe_n,
  input  logic              load_n,
  input  logic              hi_byte,
  output logic              drv_en,
  output logic [DATA_W-1:0] drv_val
);
  logic [DATA_W-1:0] lat_q;
  logic              lat_en;

  assign lat_en = capture & hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= pos;
  end

  always_comb begin
    drv_en  = !oe_n && load_n;
    drv_val = {hi_byte ? lat_q[DATA_W-1:HALF_W] : lat_q[HALF_W-1:0],
               lat_q[HALF_W-1:0]};
  end

  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> $stable(lat_q));
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && hold_n) |=> lat_q == $past(pos));
endmodule

// File: rtl/trk_pos_ctr.sv
module trk_pos_ctr
  import trk_pkg::*;
#(
  parameter int unsigned BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_stb,
  input  logic              cnt_up,
  input  logic [1:0]        res_sel,
  input  logic              hold_n,
  input  logic              oe_n,
  input  logic              hi_byte,
  input  logic              load_n,
  inout  wire  [DATA_W-1:0] bus_io,
  output logic              busy,
  output logic              dir,
  output logic              wrap_pulse
);
  logic [DATA_W-1:0] pos_w, drv_val_w;
  logic              drv_en_w, fall_w, step_w, load_w;

  assign load_w = !load_n;
  assign step_w = cnt_stb & load_n;

  trk_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_w),
    .up       (cnt_up),
    .load_en  (load_w),
    .load_val (bus_io),
    .res_sel  (res_sel),
    .pos      (pos_w),
    .dir      (dir),
    .wrap     (wrap_pulse)
  );

  trk_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (step_w | load_w),
    .busy  (busy),
    .fall  (fall_w)
  );

  trk_out_latch u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (fall_w),
    .hold_n  (hold_n),
    .pos     (pos_w),
    .oe_n    (oe_n),
    .load_n  (load_n),
    .hi_byte (hi_byte),
    .drv_en  (drv_en_w),
    .drv_val (drv_val_w)
  );

  assign bus_io = drv_en_w ? drv_val_w : {DATA_W{1'bz}};

  assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n || oe_n) |-> !drv_en_w);
  assert_preset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> pos_w == ($past(bus_io) & res_mask(res_e'($past(res_sel)))));
  assert_wrap_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> busy);
endmodule

// File: tb/trk_pos_ctr_test.sv
module trk_pos_ctr_test;
  localparam int unsigned B = 4;

  logic clk = 1'b0;
  logic rst_n, cnt_stb, cnt_up, hold_n, oe_n, hi_byte, load_n;
  logic [1:0]  res_sel;
  logic        tb_en;
  logic [15:0] tb_val;
  wire  [15:0] bus;
  logic busy, dir, wrap_pulse;

  assign bus = tb_en ? tb_val : 16'hzzzz;

  trk_pos_ctr #(.BUSY_CYC(B)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_stb(cnt_stb), .cnt_up(cnt_up),
    .res_sel(res_sel), .hold_n(hold_n), .oe_n(oe_n), .hi_byte(hi_byte),
    .load_n(load_n), .bus_io(bus), .busy(busy), .dir(dir),
    .wrap_pulse(wrap_pulse)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] pos_m, lat_m;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stp(input logic [1:0] s);
    return 16'(1) << (6 - 2 * int'(s));
  endfunction
  function automatic logic [15:0] msk(input logic [1:0] s);
    return ~(stp(s) - 16'd1);
  endfunction

  // monitor: compares the bus against the scoreboard head
  always @(negedge clk) begin
    if (rd_req) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus === e, t, bus, e);
      rd_req = 1'b0;
    end
  end

  task automatic read_lat(input logic hi, input string t);
    @(negedge clk);
    oe_n = 1'b0; hi_byte = hi;
    exp_q.push_back({hi ? lat_m[15:8] : lat_m[7:0], lat_m[7:0]});
    tag_q.push_back(t);
    rd_req = 1'b1;
    wait (rd_req == 1'b0);
    oe_n = 1'b1;
  endtask

  task automatic settle();
    repeat (B) @(negedge clk);
    if (hold_n) lat_m = pos_m;
  endtask

  task automatic step(input logic up, input logic exp_wrap, input string t);
    logic [15:0] m;
    @(negedge clk);
    cnt_stb = 1'b1; cnt_up = up;
    m = pos_m & msk(res_sel);
    pos_m = up ? m + stp(res_sel) : m - stp(res_sel);
    @(negedge clk);
    cnt_stb = 1'b0;
    chk(wrap_pulse == exp_wrap, {t, " R4 wrap"}, 16'(wrap_pulse), 16'(exp_wrap));
    chk(dir == up, {t, " R3 dir"}, 16'(dir), 16'(up));
    @(negedge clk);
    chk(wrap_pulse == 1'b0, {t, " R4 single"}, 16'(wrap_pulse), 16'd0);
    settle();
  endtask

  task automatic preset(input logic [15:0] v, input logic with_stb, input string t);
    @(negedge clk);
    load_n = 1'b0; tb_en = 1'b1; tb_val = v; cnt_stb = with_stb; cnt_up = 1'b1;
    oe_n = 1'b0;
    pos_m = v & msk(res_sel);
    @(negedge clk);
    // R7: load_n low overrides oe_n; bench pattern must be intact
    chk(bus === v, {t, " R7 quiet on load"}, bus, v);
    load_n = 1'b1; tb_en = 1'b0; cnt_stb = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_stb = 1'b0; cnt_up = 1'b1; res_sel = 2'b11;
    hold_n = 1'b1; oe_n = 1'b1; hi_byte = 1'b1; load_n = 1'b1;
    tb_en = 1'b0; tb_val = '0; pos_m = '0; lat_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", 16'(busy), 16'd0);
    chk(wrap_pulse == 1'b0, "R1 wrap", 16'(wrap_pulse), 16'd0);
    chk(dir == 1'b1, "R1 dir", 16'(dir), 16'd1);
    read_lat(1'b1, "R1 latch zero");
    // R7: oe_n high, block silent, bench pattern survives
    @(negedge clk);
    tb_en = 1'b1; tb_val = 16'hA5C3;
    @(negedge clk);
    chk(bus === 16'hA5C3, "R7 quiet when oe_n high", bus, 16'hA5C3);
    tb_en = 1'b0;

    // R5 busy window length
    @(negedge clk);
    cnt_stb = 1'b1; cnt_up = 1'b1;
    pos_m = pos_m + 16'd1;
    @(negedge clk);
    cnt_stb = 1'b0;
    for (int k = 1; k <= B; k++) begin
      chk(busy == 1'b1, "R5 busy held", 16'(busy), 16'd1);
      @(negedge clk);
    end
    chk(busy == 1'b0, "R5 busy falls", 16'(busy), 16'd0);
    lat_m = pos_m;
    read_lat(1'b1, "R6 latch after busy");

    // R3 16-bit counting up then down through zero
    step(1'b1, 1'b0, "R3 up16");
    step(1'b1, 1'b0, "R3 up16");
    read_lat(1'b1, "R3 value 3");
    step(1'b0, 1'b0, "R3 dn16");
    step(1'b0, 1'b0, "R3 dn16");
    step(1'b0, 1'b0, "R3 dn16");
    step(1'b0, 1'b1, "R4 dn16 wrap");
    read_lat(1'b1, "R4 value after down wrap");

    // R2/R4 10-bit up wrap
    res_sel = 2'b00;
    preset(16'hFFFF, 1'b0, "R9 preset10");
    read_lat(1'b1, "R2 masked preset 10");
    step(1'b1, 1'b1, "R4 up10 wrap");
    read_lat(1'b1, "R4 zero after up wrap");

    // R2/R8 12-bit step size and byte select
    res_sel = 2'b01;
    preset(16'h1234, 1'b0, "R9 preset12");
    step(1'b1, 1'b0, "R2 up12");
    read_lat(1'b0, "R8 low byte on upper lines");
    read_lat(1'b1, "R8 high byte on upper lines");

    // R2/R4 14-bit down wrap
    res_sel = 2'b10;
    preset(16'h0000, 1'b0, "R9 preset14");
    step(1'b0, 1'b1, "R4 dn14 wrap");
    read_lat(1'b1, "R2 value 14");

    // R6 hold freezes latch
    hold_n = 1'b0;
    step(1'b1, 1'b1, "R6 held step");
    read_lat(1'b1, "R6 frozen latch");
    hold_n = 1'b1;
    step(1'b1, 1'b0, "R6 released step");
    read_lat(1'b1, "R6 latch after release");

    // R9 preset wins over a simultaneous strobe
    res_sel = 2'b11;
    preset(16'h7FFF, 1'b1, "R9 priority");
    read_lat(1'b1, "R9 preset over strobe");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule